// File: doc/BRIEF.md
# Accumulator, Index and Stack Register File

This block keeps the programmer-visible state of a small 8-bit processor core: two byte accumulators that can also be handled as one 16-bit accumulator, two 16-bit index registers, a 16-bit stack pointer and a 16-bit program counter. These registers do not take part in memory decoding. They are reached only through a dedicated write port and a dedicated read port, each selected by a 3-bit register code.

Alongside storage, the block forms an indexed effective address. It takes the chosen index register and adds an unsigned 8-bit displacement from the instruction. It also supplies the byte address for stack traffic. The stack pointer always points at the next free byte. A push therefore uses the current pointer and then moves it down by one. A pull first moves the pointer up by one and uses the new value. Instruction decode, arithmetic, bus timing and interrupt handling sit outside this block.

Top module: `cpu_regfile`

## Requirements
- R1: After a synchronous reset, every register reads zero, the stack pointer reads `SP_INIT` (default 0x0000) and `stk_err` is low.
- R2: Register codes on `wr_sel` and `rd_sel` are: 0 = accumulator A, 1 = accumulator B, 2 = double accumulator, 3 = index X, 4 = index Y, 5 = stack pointer, 6 = program counter, 7 = none. A byte register is written from `wr_data[7:0]` and is read back zero-extended on `rd_data`.
- R3: The double accumulator reads as {A, B}, with A as the high byte. Writing it loads A from `wr_data[15:8]` and B from `wr_data[7:0]` in the same cycle.
- R4: X and Y are independent 16-bit registers. Writing one leaves the other unchanged.
- R5: `ea` = (X when `idx_sel`=0, Y when `idx_sel`=1) + zero-extended `offset`, modulo 65536, as a combinational output.
- R6: While `push` is high, `stk_addr` equals the current stack pointer, and at the clock edge the pointer decreases by one. From 0x0000 it wraps to 0xFFFF.
- R7: While `pull` is high and `push` is low, `stk_addr` equals the stack pointer plus one, and at the clock edge the pointer becomes that value. From 0xFFFF it wraps to 0x0000.
- R8: When `push` and `pull` are high together, the push behaviour of R6 applies and `stk_err` is high. Otherwise `stk_err` is low. With neither request, `stk_addr` equals the stack pointer and the pointer holds.
- R9: A stack-pointer write through the write port in the same cycle as a push or pull loads the written value, and the push or pull adjustment is dropped.
- R10: A write with `wr_sel` = 7, or with `wr_en` low, changes no register.
- R11: The program counter is a 16-bit register written and read through the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | 16 | Write value (low byte for byte registers) |
| rd_sel | input | 3 | Register code for the read |
| rd_data | output | 16 | Selected register value, byte registers zero-extended |
| idx_sel | input | 1 | Index base for the effective address: 0 = X, 1 = Y |
| offset | input | 8 | Unsigned instruction displacement |
| ea | output | 16 | Effective address |
| push | input | 1 | Byte push request |
| pull | input | 1 | Byte pull request |
| stk_addr | output | 16 | Address for the current stack byte |
| stk_err | output | 1 | Push and pull requested together |

## Verification
The wrap cases at both ends of the stack are the hardest conditions to reach from the ports, because they require the pointer to sit on 0x0000 or 0xFFFF exactly when a push or pull arrives. The bench loads these boundary values directly through the write port and then issues single requests. It also walks a run of pushes and pulls across the zero boundary. The effective-address adder is swept over every offset value for bases chosen so that the sum carries out of bit 15, once through X and once through Y.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SEL_W  = 3;
    localparam int NUM_IDX = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_A    = 3'd0,
        SEL_B    = 3'd1,
        SEL_D    = 3'd2,
        SEL_X    = 3'd3,
        SEL_Y    = 3'd4,
        SEL_SP   = 3'd5,
        SEL_PC   = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
        word_t    data;
    } wr_req_t;

    typedef struct packed {
        logic push;
        logic pull;
    } stk_req_t;

    function automatic word_t offset_add(input word_t base, input byte_t off);
        return base + word_t'(off);
    endfunction

    function automatic word_t zext_byte(input byte_t b);
        return word_t'(b);
    endfunction

endpackage

// File: rtl/acc_pair.sv
module acc_pair
    import regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    output byte_t   acc_hi,
    output byte_t   acc_lo
);
    byte_t hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr.en) begin
            case (wr.sel)
                SEL_A: hi_q <= wr.data[BYTE_W-1:0];
                SEL_B: lo_q <= wr.data[BYTE_W-1:0];
                SEL_D: begin
                    hi_q <= wr.data[WORD_W-1:BYTE_W];
                    lo_q <= wr.data[BYTE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

    // R3: a double-accumulator write splits across both bytes
    a_r3_double_split: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_D) |=> ({acc_hi, acc_lo} == $past(wr.data)));

    // R2: a write to A leaves B alone
    a_r2_a_keeps_b: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_A) |=> $stable(acc_lo));

endmodule

// File: rtl/index_bank.sv
module index_bank
    import regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  logic    idx_sel,
    input  byte_t   offset,
    output word_t   idx_x,
    output word_t   idx_y,
    output word_t   ea
);
    word_t idx_q [NUM_IDX];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_X : SEL_Y;
        always_ff @(posedge clk) begin
            if (rst)
                idx_q[g] <= '0;
            else if (wr.en && wr.sel == MY_SEL)
                idx_q[g] <= wr.data;
        end
    end

    assign idx_x = idx_q[0];
    assign idx_y = idx_q[1];
    assign ea    = offset_add(idx_sel ? idx_q[1] : idx_q[0], offset);

    // R4: writing X does not disturb Y
    a_r4_x_keeps_y: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_X) |=> $stable(idx_y));

    // R4: writing Y does not disturb X
    a_r4_y_keeps_x: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_Y) |=> $stable(idx_x));

    // R5: zero offset yields the base itself
    always_comb begin
        if (!rst && offset == '0)
            a_r5_zero_offset: assert (ea == (idx_sel ? idx_y : idx_x));
    end

endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import regfile_pkg::*;
#(
    parameter logic [regfile_pkg::WORD_W-1:0] SP_INIT = '0
)(
    input  logic     clk,
    input  logic     rst,
    input  wr_req_t  wr,
    input  stk_req_t req,
    output word_t    sp,
    output word_t    addr,
    output logic     err
);
    word_t sp_q, sp_inc, sp_dec;
    logic  sp_wr;

    assign sp_inc = sp_q + word_t'(1);
    assign sp_dec = sp_q - word_t'(1);
    assign sp_wr  = wr.en && (wr.sel == SEL_SP);

    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= SP_INIT;
        else if (sp_wr)
            sp_q <= wr.data;
        else if (req.push)
            sp_q <= sp_dec;
        else if (req.pull)
            sp_q <= sp_inc;
    end

    always_comb begin
        if (!req.push && req.pull)
            addr = sp_inc;
        else
            addr = sp_q;
    end

    assign err = req.push & req.pull;
    assign sp  = sp_q;

    // R6: a push moves the pointer down by one
    a_r6_push_dec: assert property (@(posedge clk) disable iff (rst)
        (req.push && !sp_wr) |=> (sp == $past(addr) - word_t'(1)));

    // R7: a lone pull leaves the pointer on the address it used
    a_r7_pull_lands: assert property (@(posedge clk) disable iff (rst)
        (req.pull && !req.push && !sp_wr) |=> (sp == $past(addr)));

    // R8: on conflict the push address is used
    a_r8_conflict_push: assert property (@(posedge clk) disable iff (rst)
        err |-> (addr == sp));

    // R9: an explicit write beats any adjustment
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        sp_wr |=> (sp == $past(wr.data)));

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import regfile_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'h0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic        idx_sel,
    input  logic [7:0]  offset,
    output logic [15:0] ea,
    input  logic        push,
    input  logic        pull,
    output logic [15:0] stk_addr,
    output logic        stk_err
);
    wr_req_t  wr;
    stk_req_t req;
    byte_t    acc_hi, acc_lo;
    word_t    idx_x, idx_y, sp, pc_q;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;
    assign req.push = push;
    assign req.pull = pull;

    acc_pair u_acc (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo)
    );

    index_bank u_idx (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .idx_sel (idx_sel),
        .offset  (offset),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .ea      (ea)
    );

    stack_unit #(.SP_INIT(SP_INIT)) u_stk (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .req  (req),
        .sp   (sp),
        .addr (stk_addr),
        .err  (stk_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (wr.en && wr.sel == SEL_PC)
            pc_q <= wr.data;
    end

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_A:   rd_data = zext_byte(acc_hi);
            SEL_B:   rd_data = zext_byte(acc_lo);
            SEL_D:   rd_data = {acc_hi, acc_lo};
            SEL_X:   rd_data = idx_x;
            SEL_Y:   rd_data = idx_y;
            SEL_SP:  rd_data = sp;
            SEL_PC:  rd_data = pc_q;
            default: rd_data = '0;
        endcase
    end

    // R11: a program-counter write is visible on the next cycle
    a_r11_pc_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd6) |=> (pc_q == $past(wr_data)));

    // R10: code 7 touches nothing
    a_r10_none_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd7 && !push && !pull) |=>
        ($stable(pc_q) && $stable(sp) && $stable(idx_x) && $stable(idx_y)
         && $stable(acc_hi) && $stable(acc_lo)));

endmodule

// File: tb/tb_cpu_regfile.sv
module tb_cpu_regfile;
    localparam time CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic        idx_sel;
    logic [7:0]  offset;
    logic [15:0] ea;
    logic        push, pull;
    logic [15:0] stk_addr;
    logic        stk_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    cpu_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .idx_sel(idx_sel), .offset(offset),
        .ea(ea), .push(push), .pull(pull), .stk_addr(stk_addr), .stk_err(stk_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0; wr_sel = 3'd7; wr_data = '0;
    endtask

    function automatic logic [15:0] rd(input logic [2:0] sel);
        rd_sel = sel;
        return 16'h0;
    endfunction

    task automatic rdchk(input string req, input logic [2:0] sel, input logic [15:0] exp);
        rd_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_sp;
        rst = 1; wr_en = 0; wr_sel = 3'd7; wr_data = 0; rd_sel = 0;
        idx_sel = 0; offset = 0; push = 0; pull = 0;
        tick(); tick();
        rst = 0;
        #1;

        // R1: reset state
        for (int s = 0; s < 7; s++) rdchk("R1 reset value", 3'(s), 16'h0000);
        chk("R1 stk_err low", {15'd0, stk_err}, 16'd0);

        // R2: byte registers, zero-extended
        wr(3'd0, 16'hFF5A);
        rdchk("R2 A read", 3'd0, 16'h005A);
        rdchk("R2 B untouched", 3'd1, 16'h0000);
        wr(3'd1, 16'h77C3);
        rdchk("R2 B read", 3'd1, 16'h00C3);
        rdchk("R3 D from bytes", 3'd2, 16'h5AC3);

        // R3: D write splits
        wr(3'd2, 16'h1234);
        rdchk("R3 A high byte", 3'd0, 16'h0012);
        rdchk("R3 B low byte", 3'd1, 16'h0034);
        rdchk("R3 D read", 3'd2, 16'h1234);

        // R4: independent index registers
        wr(3'd3, 16'hFFF0);
        rdchk("R4 X read", 3'd3, 16'hFFF0);
        rdchk("R4 Y untouched", 3'd4, 16'h0000);
        wr(3'd4, 16'h8000);
        rdchk("R4 Y read", 3'd4, 16'h8000);
        rdchk("R4 X kept", 3'd3, 16'hFFF0);

        // R5: sweep all offsets with both bases
        for (int b = 0; b < 2; b++) begin
            idx_sel = b[0];
            for (int o = 0; o < 256; o++) begin
                offset = o[7:0];
                #1;
                chk("R5 ea", ea, (b == 0) ? 16'(32'hFFF0 + o) : 16'(32'h8000 + o));
            end
        end
        wr(3'd4, 16'hFF80);
        idx_sel = 1;
        for (int o = 0; o < 256; o++) begin
            offset = o[7:0];
            #1;
            chk("R5 ea wrap via Y", ea, 16'(32'hFF80 + o));
        end

        // R11: program counter
        wr(3'd6, 16'hBEEF);
        rdchk("R11 PC read", 3'd6, 16'hBEEF);

        // R10: code 7 and wr_en low are ignored
        wr_en = 1; wr_sel = 3'd7; wr_data = 16'hAAAA; tick();
        wr_en = 0; wr_sel = 3'd0; wr_data = 16'h5555; tick();
        wr_sel = 3'd7;
        rdchk("R10 A kept", 3'd0, 16'h0012);
        rdchk("R10 B kept", 3'd1, 16'h0034);
        rdchk("R10 X kept", 3'd3, 16'hFFF0);
        rdchk("R10 Y kept", 3'd4, 16'hFF80);
        rdchk("R10 SP kept", 3'd5, 16'h0000);
        rdchk("R10 PC kept", 3'd6, 16'hBEEF);

        // R6/R7: push and pull sequences across zero
        exp_sp = 16'h0002;
        wr(3'd5, exp_sp);
        rd_sel = 3'd5;
        for (int i = 0; i < 6; i++) begin
            push = 1; #1;
            chk("R6 push addr", stk_addr, exp_sp);
            chk("R8 no err on push", {15'd0, stk_err}, 16'd0);
            tick();
            exp_sp = exp_sp - 16'd1;
            chk("R6 sp after push", rd_data, exp_sp);
        end
        push = 0;
        for (int i = 0; i < 6; i++) begin
            pull = 1; #1;
            chk("R7 pull addr", stk_addr, exp_sp + 16'd1);
            tick();
            exp_sp = exp_sp + 16'd1;
            chk("R7 sp after pull", rd_data, exp_sp);
        end
        pull = 0;

        // R6 wrap from 0
        wr(3'd5, 16'h0000);
        push = 1; #1;
        chk("R6 push addr at zero", stk_addr, 16'h0000);
        tick(); push = 0;
        rdchk("R6 wrap to FFFF", 3'd5, 16'hFFFF);

        // R7 wrap from FFFF
        pull = 1; #1;
        chk("R7 pull addr wraps", stk_addr, 16'h0000);
        tick(); pull = 0;
        rdchk("R7 wrap to 0000", 3'd5, 16'h0000);

        // R8 idle and conflict
        wr(3'd5, 16'h4000);
        #1;
        chk("R8 idle addr", stk_addr, 16'h4000);
        chk("R8 idle err", {15'd0, stk_err}, 16'd0);
        tick();
        rdchk("R8 idle hold", 3'd5, 16'h4000);
        push = 1; pull = 1; #1;
        chk("R8 conflict addr", stk_addr, 16'h4000);
        chk("R8 conflict err", {15'd0, stk_err}, 16'd1);
        tick(); push = 0; pull = 0;
        rdchk("R8 conflict push wins", 3'd5, 16'h3FFF);

        // R9: SP write beats push and pull
        push = 1;
        wr(3'd5, 16'h1111);
        push = 0;
        rdchk("R9 write beats push", 3'd5, 16'h1111);
        pull = 1;
        wr(3'd5, 16'h2222);
        pull = 0;
        rdchk("R9 write beats pull", 3'd5, 16'h2222);

        // R1: reset again returns zeros
        rst = 1; tick(); rst = 0;
        for (int s = 0; s < 7; s++) rdchk("R1 re-reset", 3'(s), 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule